// File: doc/BRIEF.md
# Parked Read Line Pool

This block sits on the device side of a DRAM-style memory, between the bank column paths and the 8-bit data pins. While the shared data bus is turned toward writes, the controller can still column-read idle banks. A fill command sends the selected bank's 64-bit fragment into a small pool of holding slots. After the bus turns back, separate drain commands name a slot and stream its contents out. A plain column read still goes straight to the pins. A path splitter after the bank multiplexer sends each fragment to exactly one place: the serializer or the pool.

The pool is shared by all banks. Any bank can fill any slot. Each slot carries a valid bit. Reading an empty slot, filling an occupied slot, and issuing an output command while the serializer is still in use are each reported on a one-cycle flag. Slot count, bank count, fragment width and beat width are parameters.

Top module: `lpark_pool`

## Requirements
- R1: After reset every slot is empty, `dq_valid_o`, `col_rd_o` (with no command) and all three flags are 0. A drain of any slot right after reset reports an empty slot.
- R2: A direct read (`cmd_op_i` = 1) accepted at clock edge k drives `col_rd_o` high in the command cycle, with `col_bank_o` = `cmd_bank_i` and `col_addr_o` = `cmd_col_i`. The bank data is sampled at edge k+1. It then leaves on `dq_o` over 8 cycles following edges k+1 to k+8, with `dq_valid_o` high. Beat i carries bits [8i+7:8i].
- R3: A fill (`cmd_op_i` = 2) column-reads the named bank like R2. The fragment sampled at edge k+1 is stored in slot `cmd_slot_i` and that slot becomes valid. A fill produces no data beats.
- R4: A drain (`cmd_op_i` = 3) of a valid slot accepted at edge k streams the stored fragment with the timing and beat order of R2, and empties the slot.
- R5: A drain of an empty slot pulses `err_empty_o` in the cycle after edge k and streams 8 zero beats.
- R6: A fill into a valid slot pulses `err_overwrite_o` in the cycle after edge k+1, and the new fragment replaces the old one.
- R7: An output command (direct read or drain) arriving while a burst has more than its final beat left, or while an accepted output command waits to load, is rejected. `busy_reject_o` pulses in the cycle after the edge, `col_rd_o` stays low, and the slot named by a rejected drain keeps its contents and valid state. An output command accepted at edge k lets the next one be accepted from edge k+9.
- R8: The bank selector routes the fragment of the bank named in the command, for every bank 0 to 7.
- R9: Fills are accepted while a burst is in progress and leave that burst's beats unchanged.
- R10: Slots are independent. Filling or draining one slot leaves every other slot's data and valid state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | 0 none, 1 direct read, 2 fill slot, 3 drain slot |
| cmd_bank_i | input | 3 | Source bank for direct read and fill |
| cmd_col_i | input | 7 | Column address for direct read and fill |
| cmd_slot_i | input | 4 | Slot index for fill and drain |
| bank_rdata_i | input | 512 | Column data of all banks, bank b at bits [64b+63:64b] |
| col_rd_o | output | 1 | Column read request to the banks |
| col_bank_o | output | 3 | Bank of the column request |
| col_addr_o | output | 7 | Column of the column request |
| dq_o | output | 8 | Serialized data beat |
| dq_valid_o | output | 1 | Beat on `dq_o` is valid |
| err_empty_o | output | 1 | Drain hit an empty slot |
| err_overwrite_o | output | 1 | Fill replaced a valid slot |
| busy_reject_o | output | 1 | Output command rejected as busy |

## Verification
The assertions assume that the bank data for a command stays stable through the cycle after that command. They also assume that the same slot is never drained in the cycle right after its fill is issued. That case would race the pending write against the read-and-clear, and the design resolves it with the fill winning. The stimulus keeps within both assumptions. It issues commands no closer than every second cycle, and it draws new bank data every cycle halfway between edges. It mixes seeded random commands and gaps with directed cases: each bank in turn, fills during a running burst, double drains, overwrites, and output commands aimed into a busy serializer.

// File: rtl/lpark_pkg.sv
package lpark_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_DIRECT = 2'd1,
      OP_PARK   = 2'd2,
      OP_UNPARK = 2'd3
   } lpark_op_e;

endpackage

// File: rtl/lpark_cmd_ctl.sv
module lpark_cmd_ctl
   import lpark_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int COL_W  = 7,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [1:0]        cmd_op_i,
   input  logic [BANK_W-1:0] cmd_bank_i,
   input  logic [COL_W-1:0]  cmd_col_i,
   input  logic [SLOT_W-1:0] cmd_slot_i,
   input  logic              ser_hold_i,
   output logic              col_rd_o,
   output logic [BANK_W-1:0] col_bank_o,
   output logic [COL_W-1:0]  col_addr_o,
   output logic              rd_en_o,
   output logic [SLOT_W-1:0] rd_slot_o,
   output lpark_op_e         st_op_o,
   output logic [BANK_W-1:0] st_bank_o,
   output logic [SLOT_W-1:0] st_slot_o,
   output logic              busy_reject_o
);

   lpark_op_e         op_in;
   lpark_op_e         st_op_q;
   logic [BANK_W-1:0] st_bank_q;
   logic [SLOT_W-1:0] st_slot_q;
   logic              reject_q;
   logic              wants_out;
   logic              path_busy;
   logic              accept;

   assign op_in     = lpark_op_e'(cmd_op_i);
   assign path_busy = ser_hold_i | (st_op_q == OP_DIRECT) | (st_op_q == OP_UNPARK);
   assign wants_out = cmd_valid_i & ((op_in == OP_DIRECT) | (op_in == OP_UNPARK));
   assign accept    = cmd_valid_i & (op_in != OP_IDLE) & ~(wants_out & path_busy);

   assign col_rd_o   = accept & ((op_in == OP_DIRECT) | (op_in == OP_PARK));
   assign col_bank_o = cmd_bank_i;
   assign col_addr_o = cmd_col_i;
   assign rd_en_o    = accept & (op_in == OP_UNPARK);
   assign rd_slot_o  = cmd_slot_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_op_q   <= OP_IDLE;
         st_bank_q <= '0;
         st_slot_q <= '0;
         reject_q  <= 1'b0;
      end else begin
         st_op_q   <= accept ? op_in : OP_IDLE;
         st_bank_q <= cmd_bank_i;
         st_slot_q <= cmd_slot_i;
         reject_q  <= wants_out & path_busy;
      end
   end

   assign st_op_o       = st_op_q;
   assign st_bank_o     = st_bank_q;
   assign st_slot_o     = st_slot_q;
   assign busy_reject_o = reject_q;

   // R7
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_reject_o |-> (st_op_q == OP_IDLE));

endmodule

// File: rtl/lpark_bank_mux.sv
module lpark_bank_mux #(
   parameter int NUM_BANKS = 8,
   parameter int FRAG_W    = 64,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic [NUM_BANKS*FRAG_W-1:0] bank_rdata_i,
   input  logic [BANK_W-1:0]           sel_i,
   output logic [FRAG_W-1:0]           frag_o
);

   logic [FRAG_W-1:0] lanes [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lane
      assign lanes[b] = bank_rdata_i[b*FRAG_W +: FRAG_W];
   end

   assign frag_o = lanes[sel_i];

endmodule

// File: rtl/lpark_entry_file.sv
module lpark_entry_file #(
   parameter int NUM_SLOTS = 16,
   parameter int FRAG_W    = 64,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SLOT_W-1:0] widx_i,
   input  logic [FRAG_W-1:0] wdata_i,
   input  logic              re_i,
   input  logic [SLOT_W-1:0] ridx_i,
   output logic [FRAG_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              err_empty_o,
   output logic              err_overwrite_o
);

   logic [FRAG_W-1:0]    slot_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] valid_q;
   logic                 empty_q;
   logic                 ovw_q;

   assign rdata_o  = slot_q[ridx_i];
   assign rvalid_o = valid_q[ridx_i];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q[s]  <= '0;
            valid_q[s] <= 1'b0;
         end else if (we_i && (widx_i == SLOT_W'(s))) begin
            slot_q[s]  <= wdata_i;
            valid_q[s] <= 1'b1;
         end else if (re_i && (ridx_i == SLOT_W'(s))) begin
            valid_q[s] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= 1'b0;
         ovw_q   <= 1'b0;
      end else begin
         empty_q <= re_i & ~valid_q[ridx_i];
         ovw_q   <= we_i & valid_q[widx_i];
      end
   end

   assign err_empty_o     = empty_q;
   assign err_overwrite_o = ovw_q;

   // R3
   park_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> valid_q[$past(widx_i)]);

   // R4
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (re_i && !(we_i && (widx_i == ridx_i))) |=> !valid_q[$past(ridx_i)]);

endmodule

// File: rtl/lpark_serializer.sv
module lpark_serializer #(
   parameter int FRAG_W     = 64,
   parameter int BEAT_W     = 8,
   parameter bit LSB_FIRST  = 1'b1,
   localparam int BEATS     = FRAG_W / BEAT_W,
   localparam int CNT_W     = $clog2(BEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [FRAG_W-1:0] data_i,
   output logic [BEAT_W-1:0] dq_o,
   output logic              dq_valid_o,
   output logic              hold_o
);

   logic [FRAG_W-1:0] sh_q;
   logic [FRAG_W-1:0] sh_next;
   logic [BEAT_W-1:0] window;
   logic [CNT_W-1:0]  left_q;

   if (LSB_FIRST) begin : g_lsb
      assign window  = sh_q[BEAT_W-1:0];
      assign sh_next = sh_q >> BEAT_W;
   end else begin : g_msb
      assign window  = sh_q[FRAG_W-1 -: BEAT_W];
      assign sh_next = sh_q << BEAT_W;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load_i) begin
         sh_q   <= data_i;
         left_q <= CNT_W'(BEATS);
      end else if (left_q != '0) begin
         sh_q   <= sh_next;
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign dq_valid_o = (left_q != '0);
   assign dq_o       = dq_valid_o ? window : '0;
   assign hold_o     = (left_q > CNT_W'(1));

   // R7
   no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (left_q <= CNT_W'(1)));

endmodule

// File: rtl/lpark_pool.sv
module lpark_pool
   import lpark_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int FRAG_W    = 64,
   parameter int BEAT_W    = 8,
   parameter int NUM_SLOTS = 16,
   parameter int COL_W     = 7,
   parameter bit LSB_FIRST = 1'b1,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_valid_i,
   input  logic [1:0]                  cmd_op_i,
   input  logic [BANK_W-1:0]           cmd_bank_i,
   input  logic [COL_W-1:0]            cmd_col_i,
   input  logic [SLOT_W-1:0]           cmd_slot_i,
   input  logic [NUM_BANKS*FRAG_W-1:0] bank_rdata_i,
   output logic                        col_rd_o,
   output logic [BANK_W-1:0]           col_bank_o,
   output logic [COL_W-1:0]            col_addr_o,
   output logic [BEAT_W-1:0]           dq_o,
   output logic                        dq_valid_o,
   output logic                        err_empty_o,
   output logic                        err_overwrite_o,
   output logic                        busy_reject_o
);

   if (FRAG_W % BEAT_W != 0) begin : g_bad_beat
      $error("fragment width must be a whole number of beats");
   end
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("bank count must be a power of two of at least 2");
   end
   if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
      $error("slot count must be a power of two of at least 2");
   end

   lpark_op_e         st_op;
   logic [BANK_W-1:0] st_bank;
   logic [SLOT_W-1:0] st_slot;
   logic              rd_en;
   logic [SLOT_W-1:0] rd_slot;
   logic              ser_hold;
   logic [FRAG_W-1:0] bank_frag;
   logic [FRAG_W-1:0] ent_rdata;
   logic              ent_rvalid;
   logic [FRAG_W-1:0] held_q;
   logic              ser_load;
   logic              ent_we;
   logic [FRAG_W-1:0] ser_data;

   lpark_cmd_ctl #(.BANK_W(BANK_W), .COL_W(COL_W), .SLOT_W(SLOT_W)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid_i   (cmd_valid_i),
      .cmd_op_i      (cmd_op_i),
      .cmd_bank_i    (cmd_bank_i),
      .cmd_col_i     (cmd_col_i),
      .cmd_slot_i    (cmd_slot_i),
      .ser_hold_i    (ser_hold),
      .col_rd_o      (col_rd_o),
      .col_bank_o    (col_bank_o),
      .col_addr_o    (col_addr_o),
      .rd_en_o       (rd_en),
      .rd_slot_o     (rd_slot),
      .st_op_o       (st_op),
      .st_bank_o     (st_bank),
      .st_slot_o     (st_slot),
      .busy_reject_o (busy_reject_o)
   );

   lpark_bank_mux #(.NUM_BANKS(NUM_BANKS), .FRAG_W(FRAG_W)) u_mux (
      .bank_rdata_i (bank_rdata_i),
      .sel_i        (st_bank),
      .frag_o       (bank_frag)
   );

   // path splitter: each fragment goes to the pins or to the pool, never both
   assign ser_load = (st_op == OP_DIRECT) | (st_op == OP_UNPARK);
   assign ent_we   = (st_op == OP_PARK);
   assign ser_data = (st_op == OP_UNPARK) ? held_q : bank_frag;

   lpark_entry_file #(.NUM_SLOTS(NUM_SLOTS), .FRAG_W(FRAG_W)) u_file (
      .clk             (clk),
      .rst_n           (rst_n),
      .we_i            (ent_we),
      .widx_i          (st_slot),
      .wdata_i         (bank_frag),
      .re_i            (rd_en),
      .ridx_i          (rd_slot),
      .rdata_o         (ent_rdata),
      .rvalid_o        (ent_rvalid),
      .err_empty_o     (err_empty_o),
      .err_overwrite_o (err_overwrite_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (rd_en) begin
         held_q <= ent_rvalid ? ent_rdata : '0;
      end
   end

   lpark_serializer #(.FRAG_W(FRAG_W), .BEAT_W(BEAT_W), .LSB_FIRST(LSB_FIRST)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ser_load),
      .data_i     (ser_data),
      .dq_o       (dq_o),
      .dq_valid_o (dq_valid_o),
      .hold_o     (ser_hold)
   );

   // R3
   demux_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_load && ent_we));

   // R5
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_empty_o |=> (dq_valid_o && (dq_o == '0)));

endmodule

// File: tb/lpark_pool_tb.sv
module lpark_pool_tb;

   localparam int NB = 8;
   localparam int FW = 64;
   localparam int BW = 8;
   localparam int NS = 16;
   localparam int CW = 7;
   localparam int NBEATS = FW / BW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cmd_valid = 1'b0;
   logic [1:0]      cmd_op = '0;
   logic [2:0]      cmd_bank = '0;
   logic [CW-1:0]   cmd_col = '0;
   logic [3:0]      cmd_slot = '0;
   logic [NB*FW-1:0] bank_rdata = '0;
   logic            col_rd;
   logic [2:0]      col_bank;
   logic [CW-1:0]   col_addr;
   logic [BW-1:0]   dq;
   logic            dq_valid;
   logic            err_empty;
   logic            err_ovw;
   logic            busy_rej;

   always #4 clk = ~clk;

   lpark_pool u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid_i     (cmd_valid),
      .cmd_op_i        (cmd_op),
      .cmd_bank_i      (cmd_bank),
      .cmd_col_i       (cmd_col),
      .cmd_slot_i      (cmd_slot),
      .bank_rdata_i    (bank_rdata),
      .col_rd_o        (col_rd),
      .col_bank_o      (col_bank),
      .col_addr_o      (col_addr),
      .dq_o            (dq),
      .dq_valid_o      (dq_valid),
      .err_empty_o     (err_empty),
      .err_overwrite_o (err_ovw),
      .busy_reject_o   (busy_rej)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int free_at = 0;
   bit finished = 1'b0;
   logic [7:0]    exp_q[$];
   logic [FW-1:0] mstore [NS];
   logic [NS-1:0] mvalid = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit is_out(input logic [1:0] op);
      return (op == 2'd1) || (op == 2'd3);
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // fresh bank data every cycle, halfway between edges
   always @(negedge clk) begin
      for (int w = 0; w < NB*FW/32; w++) bank_rdata[w*32 +: 32] = $urandom();
   end

   // beat monitor (R2, R4, R5, R9)
   always @(negedge clk) begin
      if (rst_n && dq_valid && !finished) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected beat", {56'd0, dq}, 64'd0);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(dq == e, "R2/R4", "beat value", {56'd0, dq}, {56'd0, e});
         end
      end
   end

   function automatic void push_frag(input logic [FW-1:0] f);
      for (int b = 0; b < NBEATS; b++) exp_q.push_back(f[b*BW +: BW]);
   endfunction

   // issue one command; call just after a falling edge, returns 2 cycles later
   task automatic cmd(input logic [1:0] op, input logic [2:0] bank,
                      input logic [CW-1:0] col, input logic [3:0] slot);
      int e;
      bit out, acc, ovw;
      logic [FW-1:0] frag;
      logic [FW-1:0] d;
      e   = cyc + 1;
      out = is_out(op);
      acc = !(out && (e < free_at));
      ovw = 1'b0;
      cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_col = col; cmd_slot = slot;
      #1;
      chk(col_rd == (acc && (op == 2'd1 || op == 2'd2)), "R2/R7", "col_rd", {63'd0, col_rd},
          {63'd0, (acc && (op == 2'd1 || op == 2'd2))});
      if (col_rd) begin
         chk(col_bank == bank && col_addr == col, "R2", "column request",
             {54'd0, col_bank, col_addr}, {54'd0, bank, col});
      end
      @(posedge clk); @(negedge clk); #1;
      cmd_valid = 1'b0;
      frag = bank_rdata[bank*FW +: FW];
      chk(busy_rej == (out && !acc), "R7", "busy_reject", {63'd0, busy_rej}, {63'd0, (out && !acc)});
      chk(err_empty == (acc && op == 2'd3 && !mvalid[slot]), "R5", "err_empty",
          {63'd0, err_empty}, {63'd0, (acc && op == 2'd3 && !mvalid[slot])});
      if (acc) begin
         case (op)
            2'd1: begin push_frag(frag); free_at = e + 9; end
            2'd2: begin ovw = mvalid[slot]; mstore[slot] = frag; mvalid[slot] = 1'b1; end
            2'd3: begin
               d = mvalid[slot] ? mstore[slot] : '0;
               push_frag(d);
               mvalid[slot] = 1'b0;
               free_at = e + 9;
            end
            default: ;
         endcase
      end
      @(posedge clk); @(negedge clk); #1;
      chk(err_ovw == ovw, "R6", "err_overwrite", {63'd0, err_ovw}, {63'd0, ovw});
      if (acc && out) chk(dq_valid == 1'b1, "R2", "first beat timing", {63'd0, dq_valid}, 64'd1);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         chk(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(dq_valid == 1'b0 && err_empty == 1'b0 && err_ovw == 1'b0 && busy_rej == 1'b0 && col_rd == 1'b0,
          "R1", "reset outputs", {59'd0, dq_valid, err_empty, err_ovw, busy_rej, col_rd}, 64'd0);
      // R1: every slot empty after reset
      for (int s = 0; s < NS; s++) begin cmd(2'd3, 3'd0, '0, 4'(s)); idle(9); end
      // R2, R8: direct read from each bank
      for (int b = 0; b < NB; b++) begin cmd(2'd1, 3'(b), 7'(b * 5 + 1), 4'd0); idle(9); end
      // R3, R10: any bank into any slot
      cmd(2'd2, 3'd7, 7'd3, 4'd15);
      cmd(2'd2, 3'd0, 7'd9, 4'd0);
      cmd(2'd2, 3'd4, 7'd1, 4'd8);
      cmd(2'd3, 3'd0, '0, 4'd0); idle(9);
      cmd(2'd3, 3'd0, '0, 4'd15); idle(9);
      // R4, R5: second drain of the same slot is empty
      cmd(2'd3, 3'd0, '0, 4'd15); idle(9);
      // R6: overwrite
      cmd(2'd2, 3'd2, 7'd4, 4'd8);
      cmd(2'd3, 3'd0, '0, 4'd8); idle(9);
      // R7, R9: busy rejections and fills during a burst
      cmd(2'd2, 3'd5, 7'd6, 4'd3);
      cmd(2'd1, 3'd1, 7'd7, 4'd0);
      cmd(2'd3, 3'd0, '0, 4'd3);
      cmd(2'd2, 3'd6, 7'd8, 4'd4);
      cmd(2'd1, 3'd2, 7'd2, 4'd0);
      idle(2);
      cmd(2'd3, 3'd0, '0, 4'd3);
      cmd(2'd1, 3'd3, 7'd5, 4'd0);
      idle(9);
      cmd(2'd3, 3'd0, '0, 4'd4); idle(9);
      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [1:0] op;
         op = 2'(1 + ($urandom() % 3));
         cmd(op, 3'($urandom()), 7'($urandom()), 4'($urandom()));
         idle($urandom() % 4);
      end
      idle(14);
      chk(exp_q.size() == 0, "R2", "missing beats", 64'(exp_q.size()), 64'd0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule